// File: doc/BRIEF.md
# Repeated-Addition Multiply-Accumulate Engine

This block computes `acc = opA * opB + opC` on unsigned operands of `WIDTH` bits. It needs no hardware multiplier. The accumulator is seeded with `opC` and the counter with `opB`. The engine then adds `opA` once per cycle until the counter is empty. The accumulate adder and the counter decrementer are separate units, so one loop pass costs one clock cycle. The result wraps modulo 2^WIDTH.

The design has two parts:
- A controller that holds only the algorithm phase (idle, load, loop, finish) and does no arithmetic.
- A datapath that holds the accumulator, the counter and the captured multiplicand, and makes no decisions.

The controller drives the datapath through a two-strobe struct. The datapath returns one status bit, which is true when the registered count is zero.

A user pulses `start` for one cycle with the operands valid. The user then waits for `done`, which stays high with the result on `acc` until the next start.

Top module: `repadd_mac`

## Requirements
- R1: Synchronous active-high `rst` clears `acc` to 0 and drives `done` low, both visible after the clock edge that samples reset.
- R2: A `start` sampled while idle or finished captures the operands. After that same edge, `acc` equals `opC` and `done` is low.
- R3: Each loop cycle adds the captured `opA` to `acc` and removes one from the count in the same clock cycle. For opA=5, opB=3, opC=2, `acc` reads 2, 7, 12, 17 after the 1st (start) edge, then after the 3rd, 4th and 5th edges.
- R4: When `done` is high, `acc` equals (opA*opB + opC) mod 2^WIDTH.
- R5: With opB=0 no addition is made. `done` rises on the first edge after the start edge, with `acc` equal to `opC`.
- R6: With opB=1 exactly one addition is made. `acc` is opA+opC, and `done` rises on the 3rd edge after the start edge.
- R7: The loop takes exactly opB cycles. For opB>0, `done` rises on edge opB+2 after the start edge.
- R8: `done` is a level. It stays high until a start is sampled. That start drops `done` and reseeds `acc` with the fresh `opC` on the same edge.
- R9: A `start` sampled during the load or loop phase is ignored. Neither the result nor the time of `done` changes, and `opA` may change freely after the start edge.
- R10: The `WIDTH` parameter widens the operands, accumulator, counter and zero test together. The block works at widths 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; captures the operands when idle or finished |
| opA | input | WIDTH | Multiplicand, added once per loop cycle |
| opB | input | WIDTH | Multiplier, used as the loop count |
| opC | input | WIDTH | Accumulate seed |
| acc | output | WIDTH | Running sum; holds the result while `done` is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
In every loop cycle the accumulate-add and the count decrement commit on the same edge. The two therefore always coincide, and an error in either one shifts both the value and the timing. The bench runs a known trajectory and samples `acc` after every edge. It also measures the number of edges to `done` for each operand set and compares it against b+2 (or 1 for b=0), so a lost or doubled decrement is caught even when the sum happens to match. A start is also injected mid-loop with different operands, and the bench checks that it disturbs neither the result nor the latency.

// File: rtl/repadd_pkg.sv
`timescale 1ns/1ps
package repadd_pkg;

  // Phases of the algorithm only; no state carries a data value.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_LOOP = 2'd2,
    PH_FIN  = 2'd3
  } phase_t;

  // Strobes from the controller down to the datapath.
  typedef struct packed {
    logic seed;  // capture opA, acc <- opC, count <- opB
    logic step;  // acc <- acc + a, count <- count - 1
  } ctrl_strobe_t;

endpackage

// File: rtl/repadd_ctrl.sv
`timescale 1ns/1ps
module repadd_ctrl
  import repadd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cntZero,
  output ctrl_strobe_t strobe,
  output logic         done
);

  phase_t phase, phaseNext;
  logic   acceptStart;

  assign acceptStart = start && ((phase == PH_IDLE) || (phase == PH_FIN));

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (acceptStart) phaseNext = PH_LOAD;
      PH_LOAD: phaseNext = cntZero ? PH_FIN : PH_LOOP;
      PH_LOOP: phaseNext = cntZero ? PH_FIN : PH_LOOP;
      PH_FIN:  if (acceptStart) phaseNext = PH_LOAD;
    endcase
  end

  always_comb begin
    strobe.seed = acceptStart;
    strobe.step = (phase == PH_LOOP) && !cntZero;
    done        = (phase == PH_FIN);
  end

  // R8: done holds as a level until a start arrives.
  a_r8_done_level: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R9: a start during load/loop never re-enters the load phase.
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (((phase == PH_LOAD) || (phase == PH_LOOP)) && start) |=> (phase != PH_LOAD));

  // R5: an empty count in the load phase goes straight to finish.
  a_r5_skip_loop: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_LOAD) && cntZero) |=> done);

endmodule

// File: rtl/repadd_dp.sv
`timescale 1ns/1ps
module repadd_dp
  import repadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] acc,
  output logic             cntZero
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] aHeld;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] accSum;
  logic [WIDTH-1:0] countDec;

  // Two independent arithmetic units: both fire in the same cycle.
  assign accSum   = acc + aHeld;
  assign countDec = count - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      aHeld <= '0;
      acc   <= '0;
      count <= '0;
    end else if (strobe.seed) begin
      aHeld <= opA;
      acc   <= opC;
      count <= opB;
    end else if (strobe.step) begin
      acc   <= accSum;
      count <= countDec;
    end
  end

  // Status comes from the registered count only.
  assign cntZero = (count == '0);

  // R2: seeding loads acc and the count together.
  a_r2_seed: assert property (@(posedge clk) disable iff (rst)
    strobe.seed |=> (acc == $past(opC)) && (count == $past(opB)));

  // R3: one step adds and decrements in the same cycle.
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (acc == $past(acc) + $past(aHeld)) && (count == $past(count) - ONE));

  // R7: never step an empty count.
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> (count != '0));

  // R9: the captured multiplicand moves only on an accepted start.
  a_r9_a_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.seed |=> $stable(aHeld));

endmodule

// File: rtl/repadd_mac.sv
`timescale 1ns/1ps
module repadd_mac
  import repadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] acc,
  output logic             done
);

  ctrl_strobe_t strobe;
  logic         cntZero;

  repadd_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cntZero (cntZero),
    .strobe  (strobe),
    .done    (done)
  );

  repadd_dp #(.WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .opC     (opC),
    .acc     (acc),
    .cntZero (cntZero)
  );

endmodule

// File: tb/test_repadd_mac.sv
`timescale 1ns/1ps
module test_repadd_mac;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{a: 16'd5,      b: 16'd3,      c: 16'd2},
    '{a: 16'd0,      b: 16'd7,      c: 16'd9},
    '{a: 16'd1234,   b: 16'd0,      c: 16'd77},
    '{a: 16'd300,    b: 16'd1,      c: 16'd45},
    '{a: 16'hFFFF,   b: 16'd2,      c: 16'd1},
    '{a: 16'd13,     b: 16'd200,    c: 16'hFFF0},
    '{a: 16'h0101,   b: 16'h0102,   c: 16'd3},
    '{a: 16'd3,      b: 16'hFFFF,   c: 16'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] opA = '0, opB = '0, opC = '0;
  logic [7:0]  acc8;
  logic [15:0] acc16;
  logic        done8, done16;
  int          nChecks = 0;
  int          nErr = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  repadd_mac #(.WIDTH(8)) i_repadd_mac (
    .clk(clk), .rst(rst), .start(start),
    .opA(opA[7:0]), .opB(opB[7:0]), .opC(opC[7:0]),
    .acc(acc8), .done(done8));

  repadd_mac #(.WIDTH(16)) i_repadd_mac16 (
    .clk(clk), .rst(rst), .start(start),
    .opA(opA), .opB(opB), .opC(opC),
    .acc(acc16), .done(done16));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expLat(input longint b);
    return (b == 0) ? 1 : int'(b) + 2;
  endfunction

  // Pulse start (sampled by one edge); return at the negedge after it.
  task automatic pulseStart(input logic [15:0] va, vb, vc);
    @(negedge clk);
    opA = va; opB = vb; opC = vc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Run both widths; check result (R4/R10) and latency (R5/R6/R7).
  task automatic runBoth(input logic [15:0] va, vb, vc, input string tag);
    int n = 0, lat8 = -1, lat16 = -1;
    logic [7:0]  e8;
    logic [15:0] e16;
    e8  = 8'(va[7:0] * vb[7:0] + vc[7:0]);
    e16 = 16'(va * vb + vc);
    pulseStart(va, vb, vc);
    while ((lat8 < 0 || lat16 < 0) && n < 70000) begin
      @(negedge clk);
      n++;
      if (done8  && lat8  < 0) lat8  = n;
      if (done16 && lat16 < 0) lat16 = n;
    end
    chk(acc8 == e8,   "R4", {tag, " w8 result"},  acc8,  e8);
    chk(acc16 == e16, "R10", {tag, " w16 result"}, acc16, e16);
    chk(lat8 == expLat(vb[7:0]), "R7", {tag, " w8 latency"}, lat8, expLat(vb[7:0]));
    chk(lat16 == expLat(vb),     "R7", {tag, " w16 latency"}, lat16, expLat(vb));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(acc8 == 0 && acc16 == 0, "R1", "acc after reset", acc8, 0);
    chk(!done8 && !done16, "R1", "done after reset", done8, 0);
    rst = 1'b0;

    // R3: trajectory 2,7,12,17 for a=5,b=3,c=2 (8 bit)
    pulseStart(16'd5, 16'd3, 16'd2);
    chk(acc8 == 2 && !done8, "R2", "seed acc", acc8, 2);
    @(negedge clk);
    @(negedge clk); chk(acc8 == 7,  "R3", "step1", acc8, 7);
    @(negedge clk); chk(acc8 == 12, "R3", "step2", acc8, 12);
    @(negedge clk); chk(acc8 == 17, "R3", "step3", acc8, 17);
    @(negedge clk); chk(done8 && acc8 == 17, "R7", "done after b+2 edges", done8, 1);

    // Table of vectors (R4, R5, R6, R7, R10)
    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = (VECS[i].b == 0) ? "R5 b0" : (VECS[i].b == 1) ? "R6 b1" : "vec";
      runBoth(VECS[i].a, VECS[i].b, VECS[i].c, t);
    end
    // R6: b=1 gives a+c at 8 bits
    runBoth(16'd40, 16'd1, 16'd2, "R6 b1");
    chk(acc8 == 42, "R6", "b1 sum", acc8, 42);

    // Random operands
    for (int i = 0; i < 6; i++) begin
      runBoth(16'($urandom), 16'($urandom) & 16'h01FF, 16'($urandom), "rand");
    end

    // R8: done holds, then a start restarts with fresh operands
    repeat (3) begin
      @(negedge clk);
      chk(done8 && done16, "R8", "done level held", done8, 1);
    end
    pulseStart(16'd4, 16'd2, 16'd10);
    chk(!done8 && acc8 == 10, "R8", "restart reseed", acc8, 10);
    begin
      int n = 0;
      while (!done8 && n < 50) begin @(negedge clk); n++; end
      chk(acc8 == 18 && n == 4, "R8", "restart result", acc8, 18);
    end

    // R9: start mid-loop with other operands is ignored
    pulseStart(16'd5, 16'd3, 16'd2);
    opA = 16'd99;
    begin
      int n = 0;
      @(negedge clk); n++;
      opB = 16'd50; opC = 16'd77; start = 1'b1;
      @(negedge clk); n++;
      start = 1'b0;
      while (!done8 && n < 50) begin @(negedge clk); n++; end
      chk(acc8 == 17, "R9", "ignored start result", acc8, 17);
      chk(n == 5, "R9", "ignored start latency", n, 5);
    end

    // R1: reset in the middle of a run
    pulseStart(16'd7, 16'd20, 16'd1);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(acc8 == 0 && !done8, "R1", "mid-run reset acc", acc8, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(!done8, "R1", "idle after reset", done8, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule